// File: doc/BRIEF.md
# Per-Slave Priority Bus Matrix Arbiter

This block arbitrates a multi-master, multi-slave bus matrix. Five masters (CPU, DMA0, DMA1, Ethernet DMA, USB) each present a request and an address. Six slave ports each have their own fixed priority ordering: flash, program RAM, data RAM 1, data RAM 2, external bus and peripheral bridge. The top address bits of each request select the target slave. Every slave picks one master at a time. Masters that target different slaves are served in the same cycle, so transfers on separate slaves run in parallel.

Each slave reports completion of its current transfer on its own ready input. The arbiter then returns ready to the granted master. A master that loses arbitration sees ready held low, and it must keep its request and address stable until ready arrives. A grant that is not completed in its first cycle is locked to that master until the slave completes it. A request to an address that maps to no slave, or to a slave the master is not wired to, is answered at once with ready and error, and it never reaches a slave.

Top module: `bus_matrix_arbiter`

## Requirements
- R1: The target slave is the slave whose code in the address map matches bits [AW-1:AW-3] of the master's address. The default codes are flash 0, program RAM 1, data RAM 1 2, data RAM 2 3, external bus 4 and peripheral bridge 5. Codes 6 and 7 map to no slave.
- R2: Flash, program RAM, external bus and peripheral bridge serve only the CPU, DMA0 and DMA1, with the CPU first, then DMA0, then DMA1.
- R3: Data RAM 1 serves all masters in the order CPU, DMA0, DMA1, Ethernet, USB.
- R4: Data RAM 2 serves all masters in the order CPU, Ethernet, USB, DMA0, DMA1.
- R5: An idle slave grants a new request in the same cycle it is presented. When that slave's ready input is high, the master's m_ready is high in that same cycle (zero wait states).
- R6: Requests from different masters to different slaves are all granted in the same cycle.
- R7: A master that is not granted sees m_ready low and m_err low while its request is pending.
- R8: A request to an unmapped code, or to a slave the master is not wired to, gets m_ready and m_err high in the same cycle. It is never granted, whatever the slave's ready input.
- R9: A grant whose slave ready is low is held on the same master in the following cycles, even if a higher-priority request arrives. The slave is re-arbitrated only after the cycle in which its ready is high.
- R10: Each slave grants at most one master at a time. After reset, no grant is held, and with no requests all outputs are zero.
- R11: In s_gnt, bit s*5+m is the grant of slave s to master m, with master indices CPU 0, DMA0 1, DMA1 2, Ethernet 3 and USB 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_req | input | NM | Request per master, held until m_ready |
| m_addr | input | NM*AW | Address per master, master m in bits [m*AW +: AW] |
| s_ready | input | NS | Per slave: the current transfer completes this cycle |
| s_gnt | output | NS*NM | One-hot grant vector per slave |
| m_ready | output | NM | Transfer of master m completes this cycle |
| m_err | output | NM | Error response to master m (with m_ready) |

## Verification
Grants, m_ready and m_err are combinational outputs of the current requests and the held-grant state. The bench therefore drives inputs just after a falling edge and samples one time unit later, before the next rising edge. Held grants change only at a rising edge. The hold and re-arbitration tests step across exactly one rising edge between their stimuli, so each expected value is the one due in the cycle after that edge. In the table rows every slave ready is high, so no grant is held between rows and each row's expected grants follow only from the priority orders.

// File: rtl/bus_matrix_arbiter.sv
module bus_matrix_arbiter #(
  parameter int NM = 5,
  parameter int NS = 6,
  parameter int AW = 32,
  parameter int SW = 3,
  parameter int IW = 3,
  // rank r of slave s at [(s*NM+r)*IW +: IW]; all ones = empty slot
  parameter logic [NS*NM*IW-1:0] PRIO = {
    3'd7, 3'd7, 3'd2, 3'd1, 3'd0,
    3'd7, 3'd7, 3'd2, 3'd1, 3'd0,
    3'd2, 3'd1, 3'd4, 3'd3, 3'd0,
    3'd4, 3'd3, 3'd2, 3'd1, 3'd0,
    3'd7, 3'd7, 3'd2, 3'd1, 3'd0,
    3'd7, 3'd7, 3'd2, 3'd1, 3'd0},
  parameter logic [NS*SW-1:0] MAP = {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_req,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NS-1:0]    s_ready,
  output logic [NS*NM-1:0] s_gnt,
  output logic [NM-1:0]    m_ready,
  output logic [NM-1:0]    m_err
);
  localparam logic [IW-1:0] NONE = '1;

  logic [NM-1:0] conn [NS];
  logic [NM-1:0] want [NS];
  logic [NM-1:0] gnt  [NS];
  logic [NS-1:0] col  [NM];
  logic [IW-1:0] pick [NS];
  logic [IW-1:0] own_id [NS];
  logic [NS-1:0] own_v;
  logic [NM-1:0] bad;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      conn[s] = '0;
      want[s] = '0;
      for (int r = 0; r < NM; r++) begin
        logic [IW-1:0] e;
        e = PRIO[(s*NM+r)*IW +: IW];
        if (e != NONE && int'(e) < NM) conn[s][e] = 1'b1;
      end
      for (int m = 0; m < NM; m++)
        want[s][m] = m_req[m] && conn[s][m] &&
                     (m_addr[m*AW+AW-SW +: SW] == MAP[s*SW +: SW]);
    end
  end

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      logic ok;
      ok = 1'b0;
      for (int s = 0; s < NS; s++) ok = ok | want[s][m];
      bad[m] = m_req[m] & ~ok;
    end
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      pick[s] = NONE;
      for (int r = NM-1; r >= 0; r--) begin
        logic [IW-1:0] e;
        e = PRIO[(s*NM+r)*IW +: IW];
        if (e != NONE && int'(e) < NM && want[s][e]) pick[s] = e;
      end
      if (own_v[s]) pick[s] = own_id[s];
      gnt[s] = '0;
      if (pick[s] != NONE && int'(pick[s]) < NM) gnt[s][pick[s]] = 1'b1;
    end
  end

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      m_ready[m] = bad[m];
      for (int s = 0; s < NS; s++) begin
        col[m][s] = gnt[s][m];
        m_ready[m] = m_ready[m] | (gnt[s][m] & s_ready[s]);
      end
    end
  end

  assign m_err = bad;

  for (genvar s = 0; s < NS; s++) begin : g_slv
    assign s_gnt[s*NM +: NM] = gnt[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_v[s]  <= 1'b0;
        own_id[s] <= NONE;
      end else if (s_ready[s]) begin
        own_v[s]  <= 1'b0;
      end else if (pick[s] != NONE) begin
        own_v[s]  <= 1'b1;
        own_id[s] <= pick[s];
      end
    end

    // R10
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(s_gnt[s*NM +: NM]));
    // R9
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|s_gnt[s*NM +: NM] && !s_ready[s]) |=> (s_gnt[s*NM +: NM] == $past(s_gnt[s*NM +: NM])));
  end

  for (genvar m = 0; m < NM; m++) begin : g_mst
    // R1
    one_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[m]));
    // R8
    err_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_err[m] |-> (col[m] == '0));
    // R8
    err_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_err[m] |-> m_ready[m]);
  end
endmodule

// File: tb/bus_matrix_arbiter_bench.sv
module bus_matrix_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 5, NS = 6, AW = 32;

  logic clk = 0, rst_n = 0;
  logic [NM-1:0] m_req = '0;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NS-1:0] s_ready = '0;
  logic [NS*NM-1:0] s_gnt;
  logic [NM-1:0] m_ready, m_err;
  int checks = 0, fails = 0;
  bit done = 0;

  bus_matrix_arbiter u_bus_matrix_arbiter (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr),
    .s_ready(s_ready), .s_gnt(s_gnt), .m_ready(m_ready), .m_err(m_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [4:0]  req;
    logic [14:0] code;  // USB,ETH,DMA1,DMA0,CPU
    logic [5:0]  rdy;
    logic [17:0] win;   // winner per slave s5..s0, 7 = none
    logic [4:0]  mrdy;
    logic [4:0]  merr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{5'b00001, {3'd0,3'd0,3'd0,3'd0,3'd0}, 6'h3f, {3'd7,3'd7,3'd7,3'd7,3'd7,3'd0}, 5'b00001, 5'b0},
    '{5'b00110, {3'd0,3'd0,3'd0,3'd0,3'd0}, 6'h3f, {3'd7,3'd7,3'd7,3'd7,3'd7,3'd1}, 5'b00010, 5'b0},
    '{5'b11111, {3'd2,3'd2,3'd2,3'd2,3'd2}, 6'h3f, {3'd7,3'd7,3'd7,3'd0,3'd7,3'd7}, 5'b00001, 5'b0},
    '{5'b11110, {3'd2,3'd2,3'd2,3'd2,3'd2}, 6'h3f, {3'd7,3'd7,3'd7,3'd1,3'd7,3'd7}, 5'b00010, 5'b0},
    '{5'b11100, {3'd2,3'd2,3'd2,3'd2,3'd2}, 6'h3f, {3'd7,3'd7,3'd7,3'd2,3'd7,3'd7}, 5'b00100, 5'b0},
    '{5'b11000, {3'd2,3'd2,3'd2,3'd2,3'd2}, 6'h3f, {3'd7,3'd7,3'd7,3'd3,3'd7,3'd7}, 5'b01000, 5'b0},
    '{5'b11110, {3'd3,3'd3,3'd3,3'd3,3'd3}, 6'h3f, {3'd7,3'd7,3'd3,3'd7,3'd7,3'd7}, 5'b01000, 5'b0},
    '{5'b10110, {3'd3,3'd3,3'd3,3'd3,3'd3}, 6'h3f, {3'd7,3'd7,3'd4,3'd7,3'd7,3'd7}, 5'b10000, 5'b0},
    '{5'b00110, {3'd3,3'd3,3'd3,3'd3,3'd3}, 6'h3f, {3'd7,3'd7,3'd1,3'd7,3'd7,3'd7}, 5'b00010, 5'b0},
    '{5'b11111, {3'd2,3'd3,3'd4,3'd1,3'd0}, 6'h3f, {3'd7,3'd2,3'd3,3'd4,3'd1,3'd0}, 5'b11111, 5'b0},
    '{5'b11000, {3'd5,3'd0,3'd0,3'd0,3'd0}, 6'h3f, {3'd7,3'd7,3'd7,3'd7,3'd7,3'd7}, 5'b11000, 5'b11000},
    '{5'b00011, {3'd0,3'd0,3'd0,3'd7,3'd6}, 6'h3f, {3'd7,3'd7,3'd7,3'd7,3'd7,3'd7}, 5'b00011, 5'b00011},
    '{5'b00101, {3'd0,3'd0,3'd5,3'd0,3'd5}, 6'h3f, {3'd0,3'd7,3'd7,3'd7,3'd7,3'd7}, 5'b00001, 5'b0},
    '{5'b00000, {3'd0,3'd0,3'd0,3'd0,3'd0}, 6'h3f, {3'd7,3'd7,3'd7,3'd7,3'd7,3'd7}, 5'b00000, 5'b0}
  };

  function automatic string row_tag(int i);
    case (i)
      0: return "R2 R5 R11";
      1: return "R2 R7";
      2, 3, 4, 5: return "R3";
      6, 7, 8: return "R4";
      9: return "R1 R6";
      10: return "R8";
      11: return "R1 R8";
      12: return "R2";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [NS*NM-1:0] win2gnt(logic [17:0] w);
    logic [NS*NM-1:0] g = '0;
    for (int s = 0; s < NS; s++)
      if (w[s*3 +: 3] != 3'd7) g[s*NM + int'(w[s*3 +: 3])] = 1'b1;
    return g;
  endfunction

  task automatic drive(logic [4:0] req, logic [14:0] code, logic [5:0] rdy);
    m_req = req;
    s_ready = rdy;
    for (int m = 0; m < NM; m++)
      m_addr[m*AW +: AW] = {code[m*3 +: 3], 29'(32'h100 * m + 32'h40)};
  endtask

  task automatic check(string tag, logic [NS*NM-1:0] eg, logic [4:0] er, logic [4:0] ee);
    checks++;
    if (s_gnt !== eg || m_ready !== er || m_err !== ee) begin
      fails++;
      $display("FAIL %s: gnt=%h rdy=%b err=%b expected gnt=%h rdy=%b err=%b",
               tag, s_gnt, m_ready, m_err, eg, er, ee);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R10 reset idle", '0, '0, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].req, TBL[i].code, TBL[i].rdy);
      #1;
      check($sformatf("%s row %0d", row_tag(i), i), win2gnt(TBL[i].win), TBL[i].mrdy, TBL[i].merr);
    end

    // hold: DMA1 on flash with slave not ready
    @(negedge clk);
    drive(5'b00100, 15'd0, 6'h00);
    #1 check("R7 DMA1 waits on flash", 30'h4, 5'b00000, 5'b0);
    @(negedge clk);
    drive(5'b00101, 15'd0, 6'h00);
    #1 check("R9 held against CPU", 30'h4, 5'b00000, 5'b0);
    @(negedge clk);
    drive(5'b00101, 15'd0, 6'h01);
    #1 check("R9 held grant completes", 30'h4, 5'b00100, 5'b0);
    @(negedge clk);
    drive(5'b00001, 15'd0, 6'h01);
    #1 check("R9 rearbitrated to CPU", 30'h1, 5'b00001, 5'b0);

    // unconnected master never granted even while slave stalls
    @(negedge clk);
    drive(5'b01000, 15'd0, 6'h00);
    #1 check("R8 ETH to flash", '0, 5'b01000, 5'b01000);
    @(negedge clk);
    #1 check("R8 ETH to flash again", '0, 5'b01000, 5'b01000);

    // parallel with one stall
    @(negedge clk);
    drive(5'b00011, {3'd0,3'd0,3'd0,3'd3,3'd2}, 6'b001000);
    #1 check("R6 parallel dram1 stall dram2 go", (30'h1 << 10) | (30'h1 << 16), 5'b00010, 5'b0);
    @(negedge clk);
    drive(5'b00001, {3'd0,3'd0,3'd0,3'd0,3'd2}, 6'b000100);
    #1 check("R9 CPU completes on dram1", 30'h1 << 10, 5'b00001, 5'b0);
    @(negedge clk);
    drive(5'b00000, 15'd0, 6'h3f);
    #1 check("R10 idle after release", '0, '0, '0);

    done = 1;
    summary();
    $finish;
  end
endmodule